// File: doc/BRIEF.md
# Programmable Character-Set Membership Bank

This block decides, once per clock, whether an 8-bit character belongs to a set that software has programmed. Each comparator slot keeps a 32-bit control word. The word has two 16-entry halves. The low half is indexed by the character's low nibble and the high half by its high nibble. A slot reports a hit only when both selected bits are set. One slot can therefore hold any set that is the cross product of a set of low nibbles and a set of high nibbles. That ranges from a single character up to all 256 codes.

A set that is not such a cross product is split across several slots. The slot outputs are ORed, so the bank matches the union of the slot sets. If two characters share one slot, their nibbles can recombine into extra codes (a collision). Choosing words that avoid this is the job of whoever computes them; that calculation is not part of this block.

Control words arrive through a write port that selects one slot. The match result is registered and appears one cycle after the character is presented.

Top module: `charset_match_bank`

## Requirements
- R1: While reset is asserted and after it is released, every control word is zero and `match_o` is 0.
- R2: Control word bits [15:0] are selected by character bits [3:0]. Bits [31:16] are selected by character bits [7:4], so bit 16+h belongs to high nibble h. A slot hits exactly when both selected bits are 1: word 32'h8000_0001 hits only 8'hF0, and word 32'h0001_8000 hits only 8'h0F.
- R3: Word 32'h0040_0006 (bits 1, 2 and 22) hits exactly the codes 8'h61 and 8'h62 among all 256.
- R4: Word 32'h0060_0006 (bits 1, 2, 21 and 22) hits exactly 8'h51, 8'h52, 8'h61 and 8'h62: the nibbles of its members recombine.
- R5: `match_o` is the OR of all slot hits, so the bank matches the union of the slot sets.
- R6: An all-ones control word hits every one of the 256 codes.
- R7: A slot whose word is zero never hits, so it does not change the union.
- R8: A word written at a clock edge is used for the character sampled at the next edge. The character sampled at the write edge is still judged with the previous word.
- R9: A write changes only the slot named by `cfg_sel_i`; all other words are kept.
- R10: `match_o` changes only at a clock edge and reflects the character present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_i | input | 8 | Character under test |
| cfg_we_i | input | 1 | Control-word write strobe |
| cfg_sel_i | input | 2 | Slot addressed by the write |
| cfg_word_i | input | 32 | Control word to store |
| match_o | output | 1 | Registered membership result |

## Verification
The bench builds the bank with its default four slots and 8-bit characters. With four slots it can run a union of two slots, a collision inside one slot, and a full slot, while the remaining slots sit at zero. Each set is checked by sweeping all 256 codes against an explicit expected set. The one-cycle timing of a write against a character sampled at the same edge is checked with directed cycle placement.

// File: rtl/charset_pkg.sv
package charset_pkg;
  localparam int CS_CHAR_W = 8;
  localparam int CS_NIB_W  = CS_CHAR_W / 2;
  localparam int CS_HALF   = 1 << CS_NIB_W;
  localparam int CS_WORD_W = 2 * CS_HALF;

  typedef logic [CS_CHAR_W-1:0] cs_char_t;
  typedef logic [CS_NIB_W-1:0]  cs_nib_t;
  typedef logic [CS_WORD_W-1:0] cs_word_t;

  function automatic cs_nib_t cs_low_nib(cs_char_t c);
    return c[CS_NIB_W-1:0];
  endfunction

  function automatic cs_nib_t cs_high_nib(cs_char_t c);
    return c[CS_CHAR_W-1:CS_NIB_W];
  endfunction

  // Membership by direct indexing; the top index bit picks the half.
  function automatic logic cs_member(cs_word_t w, cs_char_t c);
    return w[{1'b0, cs_low_nib(c)}] & w[{1'b1, cs_high_nib(c)}];
  endfunction
endpackage

// File: rtl/charset_nibble_mux.sv
module charset_nibble_mux #(
  parameter int SEL_W = 4
) (
  input  logic [(1<<SEL_W)-1:0] lines_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic                  bit_o
);
  assign bit_o = lines_i[sel_i];
endmodule

// File: rtl/charset_lookup.sv
module charset_lookup
  import charset_pkg::*;
(
  input  cs_word_t word_i,
  input  cs_char_t char_i,
  output logic     hit_o
);
  logic [1:0] half_bit;

  // half 0: low nibble into bits [15:0]; half 1: high nibble into bits [31:16]
  for (genvar h = 0; h < 2; h++) begin : g_half
    charset_nibble_mux #(.SEL_W(CS_NIB_W)) u_mux (
      .lines_i (word_i[h*CS_HALF +: CS_HALF]),
      .sel_i   (char_i[h*CS_NIB_W +: CS_NIB_W]),
      .bit_o   (half_bit[h])
    );
  end

  assign hit_o = &half_bit;
endmodule

// File: rtl/charset_slot.sv
module charset_slot
  import charset_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  cs_word_t         wdata_i,
  input  cs_char_t         char_i,
  output logic             hit_o
);
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(IDX);

  cs_word_t word_q;
  logic     load;

  assign load = we_i && (sel_i == MY_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= wdata_i;
  end

  charset_lookup u_lookup (
    .word_i (word_q),
    .char_i (char_i),
    .hit_o  (hit_o)
  );

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> word_q == $past(wdata_i));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_q));

  p_zero_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q == '0) |-> !hit_o);

  p_full_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&word_q) |-> hit_o);

  p_lookup_agrees_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o == cs_member(word_q, char_i));
endmodule

// File: rtl/charset_match_bank.sv
module charset_match_bank
  import charset_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CS_CHAR_W-1:0] char_i,
  input  logic                 cfg_we_i,
  input  logic [SEL_W-1:0]     cfg_sel_i,
  input  logic [CS_WORD_W-1:0] cfg_word_i,
  output logic                 match_o
);
  logic [NUM_SLOTS-1:0] slot_hits;
  logic                 any_hit;
  logic                 match_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    charset_slot #(.IDX(s), .SEL_W(SEL_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we_i),
      .sel_i   (cfg_sel_i),
      .wdata_i (cfg_word_i),
      .char_i  (char_i),
      .hit_o   (slot_hits[s])
    );
  end

  assign any_hit = |slot_hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= any_hit;
  end

  assign match_o = match_q;

  p_union_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_hits != '0) |=> match_o);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_hits == '0) |=> !match_o);
endmodule

// File: tb/charset_match_bank_bench.sv
module charset_match_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  char_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [31:0] cfg_word_i = '0;
  logic        match_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  charset_match_bank u_charset_match_bank (
    .clk(clk), .rst_n(rst_n), .char_i(char_i), .cfg_we_i(cfg_we_i),
    .cfg_sel_i(cfg_sel_i), .cfg_word_i(cfg_word_i), .match_o(match_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: match_o=%b expected %b (char %h)", req, act, exp, char_i);
    end
  endtask

  task automatic write_word(input int slot, input logic [31:0] w);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 2'(slot); cfg_word_i = w;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic clear_all();
    for (int s = 0; s < 4; s++) write_word(s, 32'h0);
  endtask

  task automatic sweep(input logic [255:0] exp, input string req);
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      char_i = 8'(c);
      @(negedge clk);
      check(match_o, exp[c], req);
    end
  endtask

  task automatic t_reset();
    check(match_o, 1'b0, "R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    sweep('0, "R1 R7 all slots zero");
  endtask

  task automatic t_layout();
    logic [255:0] e;
    clear_all();
    write_word(1, 32'h8000_0001);
    e = '0; e[8'hF0] = 1'b1;
    sweep(e, "R2 low0/high15");
    write_word(1, 32'h0001_8000);
    e = '0; e[8'h0F] = 1'b1;
    sweep(e, "R2 low15/high0");
  endtask

  task automatic t_pair();
    logic [255:0] e;
    clear_all();
    write_word(0, 32'h0040_0006);
    e = '0; e[8'h61] = 1'b1; e[8'h62] = 1'b1;
    sweep(e, "R3 pair a,b");
  endtask

  task automatic t_collision();
    logic [255:0] e;
    clear_all();
    write_word(0, 32'h0060_0006);
    e = '0; e[8'h51] = 1'b1; e[8'h52] = 1'b1; e[8'h61] = 1'b1; e[8'h62] = 1'b1;
    sweep(e, "R4 collision");
  endtask

  task automatic t_union();
    logic [255:0] e;
    clear_all();
    write_word(0, 32'h0040_0002);
    write_word(1, 32'h0020_0004);
    e = '0; e[8'h61] = 1'b1; e[8'h52] = 1'b1;
    sweep(e, "R5 R7 union of two slots");
  endtask

  task automatic t_full();
    clear_all();
    write_word(3, 32'hFFFF_FFFF);
    sweep('1, "R6 full word");
  endtask

  task automatic t_select();
    logic [255:0] e;
    clear_all();
    write_word(1, 32'h0040_0006);
    write_word(2, 32'h0020_0002);
    e = '0; e[8'h61] = 1'b1; e[8'h62] = 1'b1; e[8'h51] = 1'b1;
    sweep(e, "R9 other slot kept");
    write_word(1, 32'h0);
    e = '0; e[8'h51] = 1'b1;
    sweep(e, "R9 only addressed slot cleared");
  endtask

  task automatic t_timing();
    clear_all();
    @(negedge clk);
    char_i = 8'h61;
    cfg_we_i = 1'b1; cfg_sel_i = 2'd0; cfg_word_i = 32'h0040_0002;
    @(negedge clk);
    cfg_we_i = 1'b0;
    check(match_o, 1'b0, "R8 write edge uses old word");
    @(negedge clk);
    check(match_o, 1'b1, "R8 new word next edge");
    char_i = 8'h00;
    #1;
    check(match_o, 1'b1, "R10 holds until edge");
    @(negedge clk);
    check(match_o, 1'b0, "R10 follows char after edge");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_layout();
    t_pair();
    t_collision();
    t_union();
    t_full();
    t_select();
    t_timing();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule